// File: doc/BRIEF.md
# Pulse-Pause Frame Transmitter

This block sends a frame of up to 32 bits on one carrier-control line using pulse-pause encoding. Every bit opens with a short carrier-off gap. The carrier then comes back on, and the total length of the bit tells a one from a zero. Before timing, each data bit is XOR-whitened with one bit from an external keystream source. The block strobes that source once per bit so that it advances. A final carrier-off gap closes the frame. After it the block pulses done and restarts a tick counter, so a reply can be timed from the end of the frame.

All durations are counted in pulses of `tick_en`, which is the only time base. The controller is a four-state machine. ST_IDLE holds the carrier on. A start moves it to ST_GAP, or straight to ST_TAIL when the bit count is zero. ST_GAP holds the carrier off and moves to ST_MARK when the gap time runs out. ST_MARK holds the carrier on for the rest of the bit, then moves to ST_GAP for the next bit or to ST_TAIL after the last one. ST_TAIL is the closing gap and returns to ST_IDLE.

Top module: `ppe_frame_tx`

## Requirements
- R1: After reset, `carrier_on`=1, `busy`=0, `done`=0, `whiten_adv`=0 and `since_end`=0.
- R2: Bits leave least-significant first. Bit i of the frame is bit i of `frame_data`.
- R3: Every bit begins with `carrier_on`=0 for exactly 30 `tick_en` pulses, after which the carrier is turned back on.
- R4: The encoded bit is the data bit XOR `whiten_bit`, where `whiten_bit` is sampled when the bit begins. An encoded 1 lasts 150 ticks in total, so its carrier-on part is 120 ticks. An encoded 0 lasts 90 ticks in total, so its carrier-on part is 60 ticks.
- R5: `whiten_adv` pulses for one cycle exactly once per transmitted bit. The pulse falls in the first cycle of the carrier-on part of that bit.
- R6: After the last bit, one more 30-tick carrier-off gap is sent. On the cycle the carrier returns, `done` pulses for one cycle with `busy`=0.
- R7: A `bit_count` of 0 sends only the closing gap. A count above 32 is treated as 32.
- R8: A `start` that arrives while `busy`=1 is ignored and the frame in progress is unchanged.
- R9: `since_end` reads 0 in the `done` cycle. After that it counts `tick_en` pulses and saturates at its maximum value.
- R10: Durations are counted only in `tick_en` pulses, so the encoding is the same however the ticks are spaced.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_en | input | 1 | Time-base pulse; one tick per high cycle |
| start | input | 1 | Begins a frame when idle |
| frame_data | input | 32 | Frame bits, sent least-significant first |
| bit_count | input | 6 | Number of bits to send (values above 32 are clamped) |
| whiten_bit | input | 1 | Current keystream bit |
| whiten_adv | output | 1 | One-cycle strobe to advance the keystream |
| carrier_on | output | 1 | Carrier control, 1 = on |
| busy | output | 1 | Frame in progress |
| done | output | 1 | One-cycle end-of-frame pulse |
| since_end | output | 16 | Ticks elapsed since the last frame end |

## Verification
The carrier drops on the clock edge that accepts `start`. Each gap or mark ends on the edge of its last tick. So the bench samples at falling edges and counts the ticks it sees while the carrier is low or high, and compares each run with 30, 60 or 120. `whiten_adv` and `done` are registered, so each one appears one cycle after its segment ends: `whiten_adv` in the first cycle of the mark, and `done` in the cycle the carrier comes back. `since_end` is 0 in the `done` cycle and then grows by the number of ticks seen at earlier falling edges. The bench sweeps every bit count from 0 to 32, runs one frame with spaced ticks, and runs one frame with a start injected mid-frame, and checks each against this timing.

// File: rtl/ppe_pkg.sv
package ppe_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_GAP  = 2'd1,
        ST_MARK = 2'd2,
        ST_TAIL = 2'd3
    } ppe_state_e;
endpackage

// File: rtl/ppe_seg_timer.sv
module ppe_seg_timer #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             clr,
    input  logic             tick_en,
    input  logic [CNT_W-1:0] limit,
    output logic             expire
);
    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            cnt <= '0;
        end else if (run && tick_en) begin
            cnt <= cnt + 1'b1;
        end
    end

    assign expire = run && tick_en && (cnt == limit - 1'b1);

    // R3
    seg_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        run |-> (cnt < limit));
endmodule

// File: rtl/ppe_bit_shifter.sv
module ppe_bit_shifter #(
    parameter int MAX_BITS = 32,
    parameter int NB_W     = 6
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                load,
    input  logic                advance,
    input  logic [MAX_BITS-1:0] data_in,
    input  logic [NB_W-1:0]     count_in,
    input  logic                ks_bit,
    output logic                enc_bit,
    output logic                last_bit,
    output logic                zero_req
);
    localparam logic [NB_W-1:0] MAX_N = NB_W'(MAX_BITS);

    logic [MAX_BITS-1:0] sreg;
    logic [NB_W-1:0]     remain;
    logic [NB_W-1:0]     count_cl;

    assign count_cl = (count_in > MAX_N) ? MAX_N : count_in;
    assign zero_req = (count_in == '0);
    assign last_bit = (remain == NB_W'(1));

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sreg    <= '0;
            remain  <= '0;
            enc_bit <= 1'b0;
        end else if (load) begin
            sreg    <= data_in;
            remain  <= count_cl;
            enc_bit <= data_in[0] ^ ks_bit;
        end else if (advance) begin
            sreg    <= sreg >> 1;
            remain  <= remain - 1'b1;
            enc_bit <= sreg[1] ^ ks_bit;
        end
    end

    // R2
    shift_progress_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (advance && !load) |=> (remain == $past(remain) - 1'b1));
endmodule

// File: rtl/ppe_reply_timer.sv
module ppe_reply_timer #(
    parameter int REPLY_W = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               clr,
    input  logic               tick_en,
    output logic [REPLY_W-1:0] count
);
    localparam logic [REPLY_W-1:0] TOP = '1;

    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            count <= '0;
        end else if (tick_en && count != TOP) begin
            count <= count + 1'b1;
        end
    end

    // R9
    reply_sat_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (count == TOP && !clr) |=> (count == TOP));
endmodule

// File: rtl/ppe_ctrl.sv
module ppe_ctrl
    import ppe_pkg::*;
#(
    parameter int CNT_W     = 8,
    parameter int GAP_TICKS = 30,
    parameter int ONE_TICKS = 150,
    parameter int ZERO_TICKS = 90
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             zero_req,
    input  logic             last_bit,
    input  logic             enc_bit,
    input  logic             seg_end,
    output logic             load,
    output logic             advance,
    output logic             seg_clr,
    output logic             seg_run,
    output logic [CNT_W-1:0] seg_limit,
    output logic             reply_clr,
    output logic             carrier_on,
    output logic             busy,
    output logic             adv_pulse,
    output logic             done_pulse
);
    localparam logic [CNT_W-1:0] LIM_GAP  = CNT_W'(GAP_TICKS);
    localparam logic [CNT_W-1:0] LIM_ONE  = CNT_W'(ONE_TICKS - GAP_TICKS);
    localparam logic [CNT_W-1:0] LIM_ZERO = CNT_W'(ZERO_TICKS - GAP_TICKS);

    ppe_state_e state, state_nx;

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE: if (start)   state_nx = zero_req ? ST_TAIL : ST_GAP;
            ST_GAP:  if (seg_end) state_nx = ST_MARK;
            ST_MARK: if (seg_end) state_nx = last_bit ? ST_TAIL : ST_GAP;
            ST_TAIL: if (seg_end) state_nx = ST_IDLE;
            default:              state_nx = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    always_comb begin
        load       = (state == ST_IDLE) && start;
        advance    = (state == ST_MARK) && seg_end && !last_bit;
        seg_clr    = load || seg_end;
        seg_run    = (state != ST_IDLE);
        seg_limit  = (state == ST_MARK) ? (enc_bit ? LIM_ONE : LIM_ZERO) : LIM_GAP;
        reply_clr  = (state == ST_TAIL) && seg_end;
        carrier_on = !((state == ST_GAP) || (state == ST_TAIL));
        busy       = (state != ST_IDLE);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            adv_pulse  <= 1'b0;
            done_pulse <= 1'b0;
        end else begin
            adv_pulse  <= (state == ST_GAP) && seg_end;
            done_pulse <= reply_clr;
        end
    end

    // R5
    adv_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        adv_pulse |=> !adv_pulse);
    // R5
    adv_in_mark_chk: assert property (@(posedge clk) disable iff (!rst_n)
        adv_pulse |-> (state == ST_MARK));
    // R6
    done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_pulse |=> !done_pulse);
    // R6
    done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_pulse |-> (carrier_on && !busy));
    // R8
    start_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && start && !seg_end) |=> $stable(state));
endmodule

// File: rtl/ppe_frame_tx.sv
module ppe_frame_tx #(
    parameter int MAX_BITS   = 32,
    parameter int GAP_TICKS  = 30,
    parameter int ONE_TICKS  = 150,
    parameter int ZERO_TICKS = 90,
    parameter int REPLY_W    = 16
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       tick_en,
    input  logic                       start,
    input  logic [MAX_BITS-1:0]        frame_data,
    input  logic [$clog2(MAX_BITS+1)-1:0] bit_count,
    input  logic                       whiten_bit,
    output logic                       whiten_adv,
    output logic                       carrier_on,
    output logic                       busy,
    output logic                       done,
    output logic [REPLY_W-1:0]         since_end
);
    localparam int NB_W  = $clog2(MAX_BITS + 1);
    localparam int CNT_W = $clog2(ONE_TICKS + 1);

    logic             load, advance, seg_clr, seg_run, seg_end, reply_clr;
    logic             enc_bit, last_bit, zero_req;
    logic [CNT_W-1:0] seg_limit;

    ppe_ctrl #(
        .CNT_W(CNT_W), .GAP_TICKS(GAP_TICKS),
        .ONE_TICKS(ONE_TICKS), .ZERO_TICKS(ZERO_TICKS)
    ) u_ctrl (
        .clk(clk), .rst_n(rst_n), .start(start), .zero_req(zero_req),
        .last_bit(last_bit), .enc_bit(enc_bit), .seg_end(seg_end),
        .load(load), .advance(advance), .seg_clr(seg_clr), .seg_run(seg_run),
        .seg_limit(seg_limit), .reply_clr(reply_clr), .carrier_on(carrier_on),
        .busy(busy), .adv_pulse(whiten_adv), .done_pulse(done)
    );

    ppe_seg_timer #(.CNT_W(CNT_W)) u_seg (
        .clk(clk), .rst_n(rst_n), .run(seg_run), .clr(seg_clr),
        .tick_en(tick_en), .limit(seg_limit), .expire(seg_end)
    );

    ppe_bit_shifter #(.MAX_BITS(MAX_BITS), .NB_W(NB_W)) u_shift (
        .clk(clk), .rst_n(rst_n), .load(load), .advance(advance),
        .data_in(frame_data), .count_in(bit_count), .ks_bit(whiten_bit),
        .enc_bit(enc_bit), .last_bit(last_bit), .zero_req(zero_req)
    );

    ppe_reply_timer #(.REPLY_W(REPLY_W)) u_reply (
        .clk(clk), .rst_n(rst_n), .clr(reply_clr), .tick_en(tick_en),
        .count(since_end)
    );

    // R10
    carrier_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !carrier_on |-> busy);
endmodule

// File: tb/tb_ppe_frame_tx.sv
module tb_ppe_frame_tx;
    logic        clk = 0, rst_n = 0, tick_en = 0, start = 0, whiten_bit;
    logic [31:0] frame_data = 0;
    logic [5:0]  bit_count = 0;
    logic        whiten_adv, carrier_on, busy, done;
    logic [15:0] since_end;

    int checks = 0, errors = 0;
    int tdiv = 1, tcnt = 0, cyc = 0;
    logic [15:0] lfsr = 16'hACE1;
    logic        ks_zero = 0;

    int lows[64];
    int highs[64];
    int nl = 0, nh = 0, nks = 0, run = 0;
    logic prev_car = 1, prev_done = 0, dbl_done = 0;

    always #5 clk = ~clk;

    assign whiten_bit = ks_zero ? 1'b0 : lfsr[0];

    ppe_frame_tx dut (
        .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .start(start),
        .frame_data(frame_data), .bit_count(bit_count), .whiten_bit(whiten_bit),
        .whiten_adv(whiten_adv), .carrier_on(carrier_on), .busy(busy),
        .done(done), .since_end(since_end)
    );

    function automatic logic [15:0] step(input logic [15:0] s);
        return {s[0] ^ s[2] ^ s[3] ^ s[5], s[15:1]};
    endfunction

    always @(posedge clk) begin
        cyc <= cyc + 1;
        tick_en <= (tcnt == 0);
        tcnt <= (tcnt + 1 >= tdiv) ? 0 : tcnt + 1;
    end

    always @(negedge clk) begin
        if (rst_n) begin
            if (carrier_on != prev_car) begin
                if (!prev_car) begin
                    if (nl < 64) lows[nl] = run;
                    nl++;
                end else if (nl > 0) begin
                    if (nh < 64) highs[nh] = run;
                    nh++;
                end
                run = tick_en ? 1 : 0;
            end else if (tick_en) begin
                run++;
            end
            prev_car = carrier_on;
            if (whiten_adv) begin
                nks++;
                lfsr = step(lfsr);
            end
            if (done && prev_done) dbl_done = 1;
            prev_done = done;
        end
    end

    always @(posedge clk) begin
        if (cyc > 190000) begin
            errors++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic send(input logic [31:0] d, input int n, input int exp_n, input bit inj);
        logic [15:0] s;
        int bad_lo, bad_hi, mis;
        @(negedge clk);
        s = lfsr;
        nl = 0; nh = 0; nks = 0; dbl_done = 0;
        frame_data = d; bit_count = 6'(n); start = 1;
        @(negedge clk);
        start = 0;
        if (inj) begin
            repeat (200) @(negedge clk);
            frame_data = ~d; bit_count = 6'd3; start = 1;
            @(negedge clk);
            start = 0;
        end
        while (!done) @(negedge clk);
        #1;
        chk("R6 busy low at done", busy, 0);
        chk("R7 gap count", nl, exp_n + 1);
        bad_lo = 0; bad_hi = 0;
        for (int i = 0; i < nl && i < 64; i++) if (lows[i] != 30) bad_lo++;
        chk("R3 gap length", bad_lo, 0);
        for (int i = 0; i < exp_n; i++) begin
            logic e;
            e = d[i] ^ (ks_zero ? 1'b0 : s[0]);
            s = step(s);
            if (i >= nh || highs[i] != (e ? 120 : 60)) bad_hi++;
        end
        chk("R4 R2 mark lengths", bad_hi, 0);
        chk("R5 keystream advances", nks, exp_n);
        mis = 0;
        begin
            int cnt = 0;
            for (int k = 0; k < 40; k++) begin
                if (since_end != 16'(cnt)) mis++;
                if (tick_en) cnt++;
                @(negedge clk);
                #1;
            end
        end
        chk("R9 since_end counting", mis, 0);
        chk("R6 done single pulse", dbl_done, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk("R1 carrier", carrier_on, 1);
        chk("R1 busy", busy, 0);
        chk("R1 done", done, 0);
        chk("R1 whiten_adv", whiten_adv, 0);
        chk("R1 since_end", since_end, 0);
        rst_n = 1;
        repeat (3) @(negedge clk);
        ks_zero = 1;
        send(32'h0000_0005, 3, 3, 0);
        ks_zero = 0;
        for (int n = 0; n <= 32; n++)
            send(32'hA5C3_96F1 ^ (32'(n) * 32'h0101_0101), n, n, 0);
        send(32'hFFFF_FFFF, 32, 32, 0);
        send(32'h1234_5678, 40, 32, 0);
        send(32'h0000_00B4, 8, 8, 1);
        tdiv = 3;
        send(32'h0000_0E6D, 12, 12, 0);
        tdiv = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule